// File: doc/BRIEF.md
# Lockstep Output Comparator with Self-Test Injection

This block watches the output buses of two redundant processors that execute the same program. The second processor runs a fixed phase behind the first. Channel A is therefore held back by a configurable number of whole cycles, so that a word from A and the matching word from B reach the comparator in the same cycle. Every bit pair is combined by exclusive-OR, and the results are reduced to a single miscompare indication: 0 means agreement and 1 means disagreement.

The comparator is not trusted blindly. On a fixed schedule, an internal pattern generator flips one bit of the aligned B word, and the bit it flips walks across the bus from one injection to the next. In such a cycle the reduction must report a difference. If it reports agreement instead, the detection path is broken and a comparator fault is raised. A genuine disagreement and a failed self-test both latch a fail-safe request. While that request is latched, the forwarded output bus carries a fixed safe word, and only a synchronous reset releases it.

Top module: `lockstep_cmp_top`

## Requirements
- R1: With the default alignment depth of 1, the channel A word and strobe driven in cycle n are compared with the channel B word and strobe driven in cycle n+1.
- R2: A compare with both aligned strobes high and equal words leaves `err_o`, `cmp_fault_o` and `failsafe_o` low. One cycle later, `out_data` carries the aligned A word.
- R3: Outside an injection cycle, a compare with both strobes high and any differing bit sets `err_o` for one cycle after the compare cycle, and sets `failsafe_o` in the same cycle.
- R4: A compare cycle with exactly one of the two aligned strobes high counts as a mismatch, with the same outputs as R3.
- R5: When both aligned strobes are low, the data words are ignored: no error, no fault and no fail-safe, whatever the words contain.
- R6: The injection counter runs from 0 in the last reset cycle. Every cycle whose index modulo TEST_PERIOD (default 16) equals TEST_PERIOD-1 is an injection cycle. The bit flipped in aligned B starts at bit 0, advances by one position per injection, and wraps after bit DATA_W-1.
- R7: An injection cycle in which both strobes are high and the words are equal raises neither `err_o` nor `failsafe_o`.
- R8: An injection cycle in which both strobes are high and the reduced compare result is 0 (for example, because the real difference is exactly the injected bit) pulses `cmp_fault_o` and sets `failsafe_o`.
- R9: In an injection cycle, a real difference in any bit other than the injected one pulses `err_o` and leaves `cmp_fault_o` low.
- R10: Once set, `failsafe_o` stays high until a synchronous reset. While it is high, `out_data` equals SAFE_VALUE (default 8'hC3).
- R11: During reset and in the first cycle after it, `err_o`, `cmp_fault_o` and `failsafe_o` are low and `out_data` equals SAFE_VALUE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both channels |
| rst | input | 1 | Synchronous reset, active high |
| a_data | input | DATA_W | Leading channel output word |
| a_vld | input | 1 | Leading channel word strobe |
| b_data | input | DATA_W | Trailing channel output word |
| b_vld | input | 1 | Trailing channel word strobe |
| err_o | output | 1 | One-cycle pulse on a real miscompare |
| cmp_fault_o | output | 1 | One-cycle pulse when a self-test flip went unseen |
| failsafe_o | output | 1 | Latched fail-safe request |
| out_data | output | DATA_W | Aligned A word, or SAFE_VALUE when fail-safe is latched |

## Verification
The self-test flip and a genuine channel difference can land in the same compare cycle. The bench sets this up by counting cycles from reset and corrupting the B word exactly in the P-th cycle. When the corruption sits on the injected bit, the two cancel, and the bench expects a comparator fault rather than an error. When the corruption sits on a different bit, it expects an error with no fault. A second run reaches the next injection cycle to confirm that the flipped bit has moved on by one position.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

   typedef enum logic [1:0] {
      STROBE_NONE = 2'd0,
      STROBE_ONE  = 2'd1,
      STROBE_BOTH = 2'd2
   } strobe_pair_e;

   function automatic strobe_pair_e classify_strobes(input logic va, input logic vb);
      if (va && vb)      return STROBE_BOTH;
      else if (va || vb) return STROBE_ONE;
      else               return STROBE_NONE;
   endfunction

endpackage

// File: rtl/lsc_align_delay.sv
module lsc_align_delay #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_vld,
   output logic [DATA_W-1:0] out_data,
   output logic              out_vld
);

   localparam int unsigned SW = DATA_W + 1;

   generate
      if (DEPTH == 0) begin : g_pass
         assign out_data = in_data;
         assign out_vld  = in_vld;
      end else begin : g_shift
         logic [SW-1:0] stage_q [DEPTH];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= {in_vld, in_data};
               for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign out_vld  = stage_q[DEPTH-1][SW-1];
         assign out_data = stage_q[DEPTH-1][DATA_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/lsc_inject_gen.sv
module lsc_inject_gen #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned TEST_PERIOD = 16
) (
   input  logic              clk,
   input  logic              rst,
   output logic              inject,
   output logic [DATA_W-1:0] flip_mask
);

   localparam int unsigned CW = (TEST_PERIOD > 1) ? $clog2(TEST_PERIOD) : 1;
   localparam int unsigned KW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(TEST_PERIOD - 1);
   localparam logic [KW-1:0] BIT_LAST = KW'(DATA_W - 1);

   logic [CW-1:0] cnt_q;
   logic [KW-1:0] bit_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign inject = (cnt_q == CNT_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_q <= '0;
      end else if (inject) begin
         bit_q <= (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
      end
   end

   always_comb begin
      flip_mask = '0;
      if (inject) flip_mask[bit_q] = 1'b1;
   end

   p_mask_single_r6: assert property (@(posedge clk) disable iff (rst)
      $onehot0(flip_mask));

   p_inject_spacing_r6: assert property (@(posedge clk) disable iff (rst)
      inject |=> !inject);

endmodule

// File: rtl/lsc_xor_reduce.sv
module lsc_xor_reduce #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] lead_word,
   input  logic [DATA_W-1:0] trail_word,
   input  logic [DATA_W-1:0] flip_mask,
   output logic              any_diff,
   output logic              real_diff
);

   logic [DATA_W-1:0] diff_vec;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign diff_vec[i] = lead_word[i] ^ (trail_word[i] ^ flip_mask[i]);
      end
   endgenerate

   assign any_diff  = |diff_vec;
   assign real_diff = |(diff_vec & ~flip_mask);

endmodule

// File: rtl/lockstep_cmp_top.sv
module lockstep_cmp_top
   import lockstep_pkg::*;
#(
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       A_DELAY     = 1,
   parameter int unsigned       TEST_PERIOD = 16,
   parameter logic [DATA_W-1:0] SAFE_VALUE  = DATA_W'(8'hC3)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] a_data,
   input  logic              a_vld,
   input  logic [DATA_W-1:0] b_data,
   input  logic              b_vld,
   output logic              err_o,
   output logic              cmp_fault_o,
   output logic              failsafe_o,
   output logic [DATA_W-1:0] out_data
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (TEST_PERIOD < 2) begin : g_bad_period
         $error("TEST_PERIOD must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] a_al;
   logic              a_vld_al;
   logic              inject;
   logic [DATA_W-1:0] flip_mask;
   logic              any_diff;
   logic              real_diff;
   strobe_pair_e      strobes;
   logic              err_d, fault_d, fs_d;
   logic              err_q, fault_q, fs_q;
   logic [DATA_W-1:0] out_q;

   lsc_align_delay #(.DATA_W(DATA_W), .DEPTH(A_DELAY)) align_i (
      .clk      (clk),
      .rst      (rst),
      .in_data  (a_data),
      .in_vld   (a_vld),
      .out_data (a_al),
      .out_vld  (a_vld_al)
   );

   lsc_inject_gen #(.DATA_W(DATA_W), .TEST_PERIOD(TEST_PERIOD)) inj_i (
      .clk       (clk),
      .rst       (rst),
      .inject    (inject),
      .flip_mask (flip_mask)
   );

   lsc_xor_reduce #(.DATA_W(DATA_W)) cmp_i (
      .lead_word  (a_al),
      .trail_word (b_data),
      .flip_mask  (flip_mask),
      .any_diff   (any_diff),
      .real_diff  (real_diff)
   );

   assign strobes = classify_strobes(a_vld_al, b_vld);

   always_comb begin
      err_d   = 1'b0;
      fault_d = 1'b0;
      unique case (strobes)
         STROBE_ONE:  err_d = 1'b1;
         STROBE_BOTH: begin
            err_d   = real_diff;
            fault_d = inject & ~any_diff;
         end
         default: ;
      endcase
      fs_d = fs_q | err_d | fault_d;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         err_q   <= 1'b0;
         fault_q <= 1'b0;
         fs_q    <= 1'b0;
         out_q   <= SAFE_VALUE;
      end else begin
         err_q   <= err_d;
         fault_q <= fault_d;
         fs_q    <= fs_d;
         out_q   <= fs_d ? SAFE_VALUE : a_al;
      end
   end

   assign err_o       = err_q;
   assign cmp_fault_o = fault_q;
   assign failsafe_o  = fs_q;
   assign out_data    = out_q;

   p_failsafe_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      fs_q |=> fs_q);

   p_safe_word_r10: assert property (@(posedge clk) disable iff (rst)
      fs_q |-> (out_q == SAFE_VALUE));

   p_error_latches_r3: assert property (@(posedge clk) disable iff (rst)
      err_q |-> fs_q);

   p_fault_latches_r8: assert property (@(posedge clk) disable iff (rst)
      fault_q |-> fs_q);

   p_err_fault_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
      !(err_q && fault_q));

endmodule

// File: tb/lockstep_cmp_tb.sv
module lockstep_cmp_top_tb_top;

   localparam int        CLK_PERIOD = 10;
   localparam int        W          = 8;
   localparam int        P          = 16;
   localparam logic [7:0] SAFE      = 8'hC3;
   localparam int        NVEC       = 20;

   // vector fields: {a[17:10], a_vld[9], b_flip[8:1], b_vld[0]}
   localparam logic [17:0] VEC [NVEC] = '{
      {8'h00,1'b1,8'h00,1'b0}, {8'hFF,1'b1,8'h00,1'b1},
      {8'hA5,1'b1,8'h00,1'b1}, {8'h5A,1'b1,8'h00,1'b1},
      {8'h01,1'b1,8'h00,1'b1}, {8'h80,1'b0,8'h00,1'b1},
      {8'h7E,1'b1,8'hFF,1'b0}, {8'h3C,1'b1,8'h00,1'b1},
      {8'hC3,1'b1,8'h00,1'b1}, {8'h0F,1'b1,8'h00,1'b1},
      {8'hF0,1'b1,8'h00,1'b1}, {8'h55,1'b1,8'h00,1'b1},
      {8'hAA,1'b1,8'h00,1'b1}, {8'h12,1'b1,8'h00,1'b1},
      {8'h34,1'b1,8'h00,1'b1}, {8'h56,1'b1,8'h00,1'b1},
      {8'h78,1'b1,8'h00,1'b1}, {8'h9A,1'b1,8'h00,1'b1},
      {8'hBC,1'b1,8'h00,1'b1}, {8'hDE,1'b1,8'h00,1'b1}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a_data = '0;
   logic         a_vld = 1'b0;
   logic [W-1:0] b_data = '0;
   logic         b_vld = 1'b0;
   logic         err_o, cmp_fault_o, failsafe_o;
   logic [W-1:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] prev_a;
   logic       prev_va;
   logic       fs_exp;
   int         m;

   always #(CLK_PERIOD/2) clk = ~clk;

   lockstep_cmp_top #(.DATA_W(W), .A_DELAY(1), .TEST_PERIOD(P), .SAFE_VALUE(SAFE)) dut_i (
      .clk(clk), .rst(rst), .a_data(a_data), .a_vld(a_vld), .b_data(b_data), .b_vld(b_vld),
      .err_o(err_o), .cmp_fault_o(cmp_fault_o), .failsafe_o(failsafe_o), .out_data(out_data)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h (m=%0d)", req, what, act, exp, m);
      end
   endtask

   // Reset, then check the reset state (R11); starts the cycle index at 0.
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; a_vld = 1'b0; b_vld = 1'b0; a_data = '0; b_data = '0;
      @(negedge clk);
      chk("R11", "err_o", 8'(err_o), 8'h00);
      chk("R11", "cmp_fault_o", 8'(cmp_fault_o), 8'h00);
      chk("R11 R10", "failsafe_o", 8'(failsafe_o), 8'h00);
      chk("R11", "out_data", out_data, SAFE);
      rst = 1'b0;
      prev_a = '0; prev_va = 1'b0; fs_exp = 1'b0; m = 0;
   endtask

   // One compare period: B carries the previous A word xor flip (R1).
   task automatic cycle(input logic [7:0] a, input logic va, input logic [7:0] flip,
                        input logic vb, input string req);
      logic       inj, both, one, e, f;
      logic [7:0] mask, xv, out_exp;
      int         k;
      inj  = ((m % P) == P - 1);
      k    = (m / P) % W;
      mask = inj ? 8'(1 << k) : 8'h00;
      xv   = flip ^ mask;
      both = prev_va & vb;
      one  = prev_va ^ vb;
      e    = one | (both & (|(xv & ~mask)));
      f    = both & inj & (xv == 8'h00);
      fs_exp  = fs_exp | e | f;
      out_exp = fs_exp ? SAFE : prev_a;
      a_data = a; a_vld = va; b_data = prev_a ^ flip; b_vld = vb;
      @(negedge clk);
      chk(req, "err_o", 8'(err_o), 8'(e));
      chk(req, "cmp_fault_o", 8'(cmp_fault_o), 8'(f));
      chk(req, "failsafe_o", 8'(failsafe_o), 8'(fs_exp));
      chk(req, "out_data", out_data, out_exp);
      prev_a = a; prev_va = va; m++;
   endtask

   task automatic clean_run(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         cycle(8'(m * 37 + 5), 1'b1, 8'h00, (m != 0), req);
      end
   endtask

   initial begin
      do_reset();

      // Table walk: clean data patterns, idle strobes with garbage (R5),
      // and the first injection cycle at m=15 with equal words (R7).
      for (int i = 0; i < NVEC; i++) begin
         cycle(VEC[i][17:10], VEC[i][9], VEC[i][8:1], VEC[i][0], "R1 R2 R5 R7");
      end

      // R3: real difference outside injection, then R10 hold of safe word.
      do_reset();
      clean_run(3, "R2");
      cycle(8'h44, 1'b1, 8'h10, 1'b1, "R3");
      cycle(8'h55, 1'b1, 8'h00, 1'b1, "R10");
      cycle(8'h66, 1'b1, 8'h00, 1'b1, "R10");

      // R10: only reset clears the latch (checked inside do_reset).
      do_reset();
      clean_run(2, "R10");

      // R4: exactly one aligned strobe high.
      do_reset();
      cycle(8'h11, 1'b1, 8'h00, 1'b0, "R4");
      cycle(8'h22, 1'b0, 8'h00, 1'b1, "R4");
      cycle(8'h33, 1'b1, 8'h00, 1'b1, "R4");

      // R8: real difference equals the injected bit 0 at m=15.
      do_reset();
      clean_run(15, "R2");
      cycle(8'h77, 1'b1, 8'h01, 1'b1, "R8");

      // R6: second injection at m=31 flips bit 1; cancel it to see the fault.
      do_reset();
      clean_run(31, "R6 R7");
      cycle(8'h77, 1'b1, 8'h02, 1'b1, "R6 R8");

      // R9: difference on another bit during injection.
      do_reset();
      clean_run(15, "R2");
      cycle(8'h77, 1'b1, 8'h08, 1'b1, "R9");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule